// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block takes D+ and D- samples that are already synchronised to the system clock. The clock runs at a fixed multiple of the low-speed bit rate, 12 clocks per bit by default. While the bus idles, the receiver waits for a J-to-K transition. It then looks through the sync field for two consecutive K bits. The second of these ends sync, and the next bit is bit 0 of the PID. Each line transition re-centres the sampling phase, so every bit is sampled at its middle.

After lock, the receiver decodes NRZI, removes stuffed bits and assembles bytes least-significant bit first. Each good byte appears on a one-clock strobe. The first byte of a packet carries a flag marking it as the PID. An SE0 at a sampling point closes the packet. Three conditions abort a packet with a one-clock error pulse: a malformed PID, a bad stuff bit, and more bytes than the configured limit. After an abort the receiver ignores the bus until the packet's SE0 and the return to J.

Top module: `usb_ls_rx`

## Requirements
- R1: After reset, every output is low and the receiver is idle, waiting for a J-to-K transition. Line states are: J = (D+ 0, D- 1), K = (D+ 1, D- 0), SE0 = both low.
- R2: Sampling takes place CLKS_PER_BIT/2 clocks after the most recent line transition, and then every CLKS_PER_BIT clocks. Sync ends at the first pair of consecutively sampled K bits after wake-up. Packets whose bits last 11 or 13 clocks are still received when transitions are frequent.
- R3: A sampled bit equal to the previous line state decodes as 1, and a change decodes as 0. Bits fill bytes LSB first. Each completed byte is presented on rx_data_o together with a one-clock rx_valid_o pulse.
- R4: rx_pid_o is high with rx_valid_o for the first byte after sync only.
- R5: After six consecutive decoded ones, the next bit is removed from the data. The sync field's final decoded one counts toward this run.
- R6: If that removed bit decodes as 1, rx_stuff_err_o pulses for one clock, the packet is abandoned and no end-of-packet is reported.
- R7: If the first byte's bits [7:4] are not the bitwise inverse of bits [3:0], rx_pid_err_o pulses and that byte is not presented. The packet is abandoned.
- R8: A byte arriving when MAX_BYTES bytes (PID included) have already been presented is not presented. Instead rx_ovf_err_o pulses and the packet is abandoned.
- R9: SE0 at a sampling point of a packet that is still in progress gives a one-clock rx_eop_o pulse. Any incomplete byte is discarded.
- R10: If no double K is found within SYNC_WAIT_BITS sampled bits after wake-up, the receiver returns to idle with no output. An SE0 during the sync search has the same effect.
- R11: After an abort, every later bit of the packet is ignored. The receiver becomes ready again once SE0 and then J have been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_i | input | 1 | Synchronised D+ sample |
| dm_i | input | 1 | Synchronised D- sample |
| rx_valid_o | output | 1 | One-clock strobe: rx_data_o holds a received byte |
| rx_data_o | output | 8 | Received byte |
| rx_pid_o | output | 1 | Current byte is the PID |
| rx_eop_o | output | 1 | Packet ended normally on SE0 |
| rx_pid_err_o | output | 1 | PID nibble check failed |
| rx_stuff_err_o | output | 1 | Stuffed bit was not a transition |
| rx_ovf_err_o | output | 1 | Byte limit exceeded |

## Verification
The bench builds the receiver with MAX_BYTES=3 and SYNC_WAIT_BITS=12, keeping the default 12 clocks per bit. The small byte limit lets a four-byte packet trigger the overflow abort. The short sync window lets a false wake-up time out within a few hundred clocks. The bench also drives packets at 11 and 13 clocks per bit to exercise the re-centring of the sampling phase. Its table includes runs of ones that force one or two stuffed bits in a row, and a packet with a deliberately bad stuff bit.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;

  // Line state as {D+, D-}
  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_J   = 2'b01,
    LN_K   = 2'b10,
    LN_SE1 = 2'b11
  } line_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_RECV,
    ST_DROP,
    ST_WAIT_J
  } rx_state_t;

  localparam int STUFF_RUN = 6;

  function automatic line_t line_of(input logic dp, input logic dm);
    return line_t'({dp, dm});
  endfunction

  // NRZI: no change -> 1, change -> 0
  function automatic logic nrzi_bit(input logic prev_j, input logic cur_j);
    return ~(prev_j ^ cur_j);
  endfunction

  function automatic logic pid_ok(input logic [7:0] b);
    return b[7:4] == ~b[3:0];
  endfunction

endpackage

// File: rtl/usb_ls_rx_timer.sv
module usb_ls_rx_timer #(
  parameter int CLKS_PER_BIT = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_i,
  output logic       edge_o,
  output logic       sample_o
);
  localparam int CW = $clog2(CLKS_PER_BIT);
  localparam logic [CW-1:0] PH_LAST = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] PH_MID  = CW'(CLKS_PER_BIT / 2);

  logic [1:0]    line_q;
  logic [CW-1:0] ph;

  assign edge_o   = (line_i != line_q);
  assign sample_o = !edge_o && (ph == PH_MID);

  // Phase restarts at every transition; the transition clock is phase 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 2'b01;
      ph     <= '0;
    end else begin
      line_q <= line_i;
      if (edge_o)
        ph <= CW'(1);
      else if (ph == PH_LAST)
        ph <= '0;
      else
        ph <= ph + CW'(1);
    end
  end
endmodule

// File: rtl/usb_ls_rx_destuff.sv
module usb_ls_rx_destuff
  import usb_ls_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       bit_stb_i,
  input  logic       line_j_i,
  output logic       dbit_valid_o,
  output logic       dbit_o,
  output logic       stuff_err_o,
  output logic [2:0] ones_o
);
  logic       prev_j;
  logic [2:0] ones;
  logic       decoded;
  logic       is_stuff;

  assign decoded      = nrzi_bit(prev_j, line_j_i);
  assign is_stuff     = (ones == 3'(STUFF_RUN));
  assign dbit_valid_o = bit_stb_i && !is_stuff;
  assign dbit_o       = decoded;
  assign stuff_err_o  = bit_stb_i && is_stuff && decoded;
  assign ones_o       = ones;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_j <= 1'b1;
      ones   <= '0;
    end else if (start_i) begin
      prev_j <= 1'b0;      // sync ends on K
      ones   <= 3'd1;      // final sync bit decodes as 1
    end else if (bit_stb_i) begin
      prev_j <= line_j_i;
      if (is_stuff)
        ones <= '0;
      else if (decoded)
        ones <= ones + 3'd1;
      else
        ones <= '0;
    end
  end
endmodule

// File: rtl/usb_ls_rx_bytes.sv
module usb_ls_rx_bytes
  import usb_ls_rx_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  localparam int BCW = $clog2(MAX_BYTES + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           dbit_valid_i,
  input  logic           dbit_i,
  output logic           byte_done_o,
  output logic [7:0]     byte_o,
  output logic           first_o,
  output logic           pid_bad_o,
  output logic           overflow_o,
  output logic [BCW-1:0] count_o
);
  logic [7:0]     sreg;
  logic [2:0]     nbit;
  logic [BCW-1:0] cnt;

  assign byte_o      = {dbit_i, sreg[7:1]};
  assign byte_done_o = dbit_valid_i && (nbit == 3'd7);
  assign first_o     = (cnt == '0);
  assign pid_bad_o   = byte_done_o && first_o && !pid_ok(byte_o);
  assign overflow_o  = byte_done_o && (cnt == BCW'(MAX_BYTES));
  assign count_o     = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      nbit <= '0;
      cnt  <= '0;
    end else if (start_i) begin
      sreg <= '0;
      nbit <= '0;
      cnt  <= '0;
    end else if (dbit_valid_i) begin
      sreg <= byte_o;
      nbit <= nbit + 3'd1;
      if (byte_done_o && !overflow_o)
        cnt <= cnt + BCW'(1);
    end
  end
endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
  import usb_ls_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT   = 12,
  parameter int MAX_BYTES      = 8,
  parameter int SYNC_WAIT_BITS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dp_i,
  input  logic       dm_i,
  output logic       rx_valid_o,
  output logic [7:0] rx_data_o,
  output logic       rx_pid_o,
  output logic       rx_eop_o,
  output logic       rx_pid_err_o,
  output logic       rx_stuff_err_o,
  output logic       rx_ovf_err_o
);
  localparam int BCW = $clog2(MAX_BYTES + 1);
  localparam int HCW = $clog2(SYNC_WAIT_BITS + 1);

  rx_state_t      state;
  logic [HCW-1:0] hunt_cnt;
  logic           prev_k;

  line_t line;
  logic  is_j, is_k, is_se0;
  logic  line_edge, sample_stb;
  logic  lock, bit_stb;
  logic  dbit_valid, dbit, stuff_err;
  logic [2:0] ones_run;
  logic  byte_done, first_byte, pid_bad, overflow;
  logic [7:0] byte_val;
  logic [BCW-1:0] byte_cnt;
  logic  abort, good_byte;

  assign line   = line_of(dp_i, dm_i);
  assign is_j   = (line == LN_J);
  assign is_k   = (line == LN_K);
  assign is_se0 = (line == LN_SE0);

  usb_ls_rx_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .line_i({dp_i, dm_i}),
    .edge_o(line_edge), .sample_o(sample_stb)
  );

  assign lock    = (state == ST_HUNT) && sample_stb && is_k && prev_k;
  assign bit_stb = (state == ST_RECV) && sample_stb && !is_se0;

  usb_ls_rx_destuff u_destuff (
    .clk(clk), .rst_n(rst_n), .start_i(lock), .bit_stb_i(bit_stb),
    .line_j_i(is_j), .dbit_valid_o(dbit_valid), .dbit_o(dbit),
    .stuff_err_o(stuff_err), .ones_o(ones_run)
  );

  usb_ls_rx_bytes #(.MAX_BYTES(MAX_BYTES)) u_bytes (
    .clk(clk), .rst_n(rst_n), .start_i(lock), .dbit_valid_i(dbit_valid),
    .dbit_i(dbit), .byte_done_o(byte_done), .byte_o(byte_val),
    .first_o(first_byte), .pid_bad_o(pid_bad), .overflow_o(overflow),
    .count_o(byte_cnt)
  );

  assign abort     = stuff_err || pid_bad || overflow;
  assign good_byte = byte_done && !pid_bad && !overflow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      hunt_cnt       <= '0;
      prev_k         <= 1'b0;
      rx_valid_o     <= 1'b0;
      rx_data_o      <= '0;
      rx_pid_o       <= 1'b0;
      rx_eop_o       <= 1'b0;
      rx_pid_err_o   <= 1'b0;
      rx_stuff_err_o <= 1'b0;
      rx_ovf_err_o   <= 1'b0;
    end else begin
      rx_valid_o     <= 1'b0;
      rx_pid_o       <= 1'b0;
      rx_eop_o       <= 1'b0;
      rx_pid_err_o   <= 1'b0;
      rx_stuff_err_o <= 1'b0;
      rx_ovf_err_o   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (line_edge && is_k) begin
            state    <= ST_HUNT;
            hunt_cnt <= '0;
            prev_k   <= 1'b0;
          end
        end
        ST_HUNT: begin
          if (sample_stb) begin
            prev_k   <= is_k;
            hunt_cnt <= hunt_cnt + HCW'(1);
            if (is_se0)
              state <= ST_WAIT_J;
            else if (lock)
              state <= ST_RECV;
            else if (hunt_cnt == HCW'(SYNC_WAIT_BITS - 1))
              state <= ST_IDLE;
          end
        end
        ST_RECV: begin
          if (sample_stb && is_se0) begin
            rx_eop_o <= 1'b1;
            state    <= ST_WAIT_J;
          end else if (bit_stb) begin
            if (good_byte) begin
              rx_valid_o <= 1'b1;
              rx_data_o  <= byte_val;
              rx_pid_o   <= first_byte;
            end
            rx_pid_err_o   <= pid_bad;
            rx_ovf_err_o   <= overflow;
            rx_stuff_err_o <= stuff_err;
            if (abort)
              state <= ST_DROP;
          end
        end
        ST_DROP: begin
          if (sample_stb && is_se0)
            state <= ST_WAIT_J;
        end
        ST_WAIT_J: begin
          if (is_j)
            state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usb_ls_rx_chk.sv
module usb_ls_rx_chk
  import usb_ls_rx_pkg::*;
#(
  parameter int MAX_BYTES      = 8,
  parameter int SYNC_WAIT_BITS = 16
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               rx_valid_o,
  input logic                               rx_pid_o,
  input logic                               rx_eop_o,
  input logic                               rx_pid_err_o,
  input logic                               rx_stuff_err_o,
  input logic                               rx_ovf_err_o,
  input logic                               sample_stb,
  input logic [2:0]                         ones_run,
  input logic [$clog2(MAX_BYTES+1)-1:0]     byte_cnt,
  input logic [$clog2(SYNC_WAIT_BITS+1)-1:0] hunt_cnt,
  input rx_state_t                          state
);
  p_sample_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  p_pid_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pid_o |-> rx_valid_o);

  p_stuff_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stuff_err_o |-> ($past(ones_run) == 3'(STUFF_RUN)));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= ($clog2(MAX_BYTES+1))'(MAX_BYTES));

  p_eop_in_packet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eop_o |-> ($past(state) == ST_RECV));

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid_o, rx_eop_o, rx_pid_err_o, rx_stuff_err_o, rx_ovf_err_o}));

  p_hunt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HUNT) |-> (hunt_cnt < ($clog2(SYNC_WAIT_BITS+1))'(SYNC_WAIT_BITS)));

  p_drop_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_DROP) |-> !(rx_valid_o || rx_eop_o));
endmodule

bind usb_ls_rx usb_ls_rx_chk #(
  .MAX_BYTES(MAX_BYTES),
  .SYNC_WAIT_BITS(SYNC_WAIT_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rx_valid_o(rx_valid_o), .rx_pid_o(rx_pid_o), .rx_eop_o(rx_eop_o),
  .rx_pid_err_o(rx_pid_err_o), .rx_stuff_err_o(rx_stuff_err_o),
  .rx_ovf_err_o(rx_ovf_err_o), .sample_stb(sample_stb),
  .ones_run(ones_run), .byte_cnt(byte_cnt), .hunt_cnt(hunt_cnt),
  .state(state)
);

// File: tb/sim_usb_ls_rx.sv
module sim_usb_ls_rx;
  localparam int CLK_PERIOD = 10;
  localparam int CPB  = 12;
  localparam int MAXB = 3;
  localparam int SWB  = 12;

  logic clk = 1'b0, rst_n = 1'b0, dp = 1'b0, dm = 1'b1;
  logic rx_valid_o, rx_pid_o, rx_eop_o, rx_pid_err_o, rx_stuff_err_o, rx_ovf_err_o;
  logic [7:0] rx_data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_ls_rx #(.CLKS_PER_BIT(CPB), .MAX_BYTES(MAXB), .SYNC_WAIT_BITS(SWB)) u0 (
    .clk(clk), .rst_n(rst_n), .dp_i(dp), .dm_i(dm),
    .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o), .rx_pid_o(rx_pid_o),
    .rx_eop_o(rx_eop_o), .rx_pid_err_o(rx_pid_err_o),
    .rx_stuff_err_o(rx_stuff_err_o), .rx_ovf_err_o(rx_ovf_err_o)
  );

  // row: {bytes_sent[3:0], bytes[31:0] first byte in top, kind[1:0], bytes_expected[2:0]}
  // kind 0 good, 1 PID error, 2 overflow, 3 bad stuff bit
  localparam logic [40:0] VEC [10] = '{
    {4'd1, 32'hD2000000, 2'd0, 3'd1},
    {4'd3, 32'hC300FF00, 2'd0, 3'd3},
    {4'd2, 32'h4B7E0000, 2'd0, 3'd2},
    {4'd3, 32'h69FFFF00, 2'd0, 3'd3},
    {4'd1, 32'hF0000000, 2'd0, 3'd1},
    {4'd2, 32'hE13F0000, 2'd0, 3'd2},
    {4'd2, 32'hD3550000, 2'd1, 3'd0},
    {4'd1, 32'h00000000, 2'd1, 3'd0},
    {4'd4, 32'hC3112233, 2'd2, 3'd3},
    {4'd2, 32'hC3FF0000, 2'd3, 3'd1}
  };

  int checks = 0, fails = 0;
  logic [7:0] cap_d [16];
  logic       cap_p [16];
  int cap_n = 0, n_eop = 0, n_pe = 0, n_se = 0, n_oe = 0;
  logic mon_on = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (rx_valid_o) begin
        if (cap_n < 16) begin
          cap_d[cap_n] = rx_data_o;
          cap_p[cap_n] = rx_pid_o;
        end
        cap_n++;
      end
      if (rx_eop_o) n_eop++;
      if (rx_pid_err_o) n_pe++;
      if (rx_stuff_err_o) n_se++;
      if (rx_ovf_err_o) n_oe++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    cap_n = 0; n_eop = 0; n_pe = 0; n_se = 0; n_oe = 0;
  endtask

  task automatic put_j(input bit j, input int n);
    @(negedge clk);
    dp = ~j;
    dm = j;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic put_se0(input int n);
    @(negedge clk);
    dp = 1'b0;
    dm = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic send_pkt(input logic [31:0] bytes, input int nb, input int bclk,
                          input bit bad, input int trail);
    bit cur;
    int ones;
    bit pend;
    logic [7:0] cb;
    pend = bad;
    for (int i = 0; i < 8; i++) put_j((i % 2 == 1) && (i != 7), bclk);
    cur = 1'b0;
    ones = 1;
    for (int i = 0; i < nb; i++) begin
      cb = bytes[31 - 8*i -: 8];
      for (int k = 0; k < 8; k++) begin
        if (!cb[k]) cur = ~cur;
        put_j(cur, bclk);
        ones = cb[k] ? ones + 1 : 0;
        if (ones == 6) begin
          if (pend) pend = 1'b0;
          else cur = ~cur;
          put_j(cur, bclk);
          ones = 0;
        end
      end
    end
    for (int t = 0; t < trail; t++) begin
      cur = ~cur;
      put_j(cur, bclk);
    end
    put_se0(2 * bclk);
    put_j(1'b1, 4 * bclk);
  endtask

  task automatic expect_pkt(input logic [31:0] bytes, input int exp_n, input int kind,
                            input string tag);
    check(cap_n == exp_n, tag, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      check(cap_d[i] == bytes[31 - 8*i -: 8], {tag, " data R3"}, cap_d[i], bytes[31 - 8*i -: 8]);
      check(cap_p[i] == (i == 0), "R4 pid flag", cap_p[i], (i == 0));
    end
    check(n_eop == (kind == 0), "R9 eop count", n_eop, (kind == 0));
    check(n_pe == (kind == 1), "R7 pid error count", n_pe, (kind == 1));
    check(n_oe == (kind == 2), "R8 overflow count", n_oe, (kind == 2));
    check(n_se == (kind == 3), "R6 stuff error count", n_se, (kind == 3));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rx_valid_o == 1'b0, "R1 valid", rx_valid_o, 0);
    check(rx_pid_o == 1'b0, "R1 pid", rx_pid_o, 0);
    check(rx_eop_o == 1'b0, "R1 eop", rx_eop_o, 0);
    check({rx_pid_err_o, rx_stuff_err_o, rx_ovf_err_o} == 3'b000, "R1 errors",
          {rx_pid_err_o, rx_stuff_err_o, rx_ovf_err_o}, 0);
    check(rx_data_o == 8'h00, "R1 data", rx_data_o, 0);
    mon_on = 1'b1;

    // Table: good packets (R3, R5 stuffing), PID errors (R7, R11), overflow (R8), bad stuff (R6)
    foreach (VEC[r]) begin
      clear_mon();
      send_pkt(VEC[r][36:5], int'(VEC[r][40:37]), CPB, VEC[r][4:3] == 2'd3, 0);
      expect_pkt(VEC[r][36:5], int'(VEC[r][2:0]), int'(VEC[r][4:3]),
                 (VEC[r][4:3] == 2'd0) ? "R3,R5 count" : "R11 count");
    end

    // R2: slow and fast bit periods
    clear_mon();
    send_pkt(32'hC3005500, 3, 13, 1'b0, 0);
    expect_pkt(32'hC3005500, 3, 0, "R2 slow count");
    clear_mon();
    send_pkt(32'h2DAA0000, 2, 11, 1'b0, 0);
    expect_pkt(32'h2DAA0000, 2, 0, "R2 fast count");

    // R9: partial byte before SE0 is discarded
    clear_mon();
    send_pkt(32'hD2000000, 1, CPB, 1'b0, 3);
    expect_pkt(32'hD2000000, 1, 0, "R9 partial count");

    // R10: wake-up without sync times out silently
    clear_mon();
    put_j(1'b0, CPB);
    put_j(1'b1, (SWB + 4) * CPB);
    check(cap_n + n_eop + n_pe + n_se + n_oe == 0, "R10 timeout silent",
          cap_n + n_eop + n_pe + n_se + n_oe, 0);
    clear_mon();
    send_pkt(32'hE1000000, 1, CPB, 1'b0, 0);
    expect_pkt(32'hE1000000, 1, 0, "R10 after timeout count");

    // R10: SE0 during sync search
    clear_mon();
    put_j(1'b0, CPB);
    put_j(1'b1, CPB);
    put_se0(2 * CPB);
    put_j(1'b1, 4 * CPB);
    check(cap_n + n_eop + n_pe + n_se + n_oe == 0, "R10 se0 in sync silent",
          cap_n + n_eop + n_pe + n_se + n_oe, 0);
    clear_mon();
    send_pkt(32'h4B990000, 2, CPB, 1'b0, 0);
    expect_pkt(32'h4B990000, 2, 0, "R10 after se0 count");

    finish_run();
  end
endmodule